// File: doc/BRIEF.md
# Sequential Integer Divider with Truncated and Floored Remainders

This block divides a dividend by a divisor over several clock cycles and returns three results together: the quotient rounded toward zero, the remainder that goes with that quotient, and a second remainder that follows the floor convention. A second language convention rounds toward negative infinity; the floored remainder lets a design serve both conventions from one unit without extra logic downstream.

Each operand has its own signedness flag. Operands are treated as two's-complement numbers only when both flags are high; any other combination runs the operation unsigned. The unit works on magnitudes with a restoring shift-and-subtract loop that yields one quotient bit per cycle. It then applies the sign fix-ups in the cycle that produces the last quotient bit. A zero divisor does not raise any exception. It produces fixed, documented values.

A caller pulses `start_i` while `busy_o` is low. `done_o` pulses once when the results are ready, and the result ports hold their values until the next operation finishes.

Top module: `sdiv_floor`

## Requirements
- R1: In signed mode with a nonzero divisor, `quot_o` equals the exact quotient rounded toward zero. It is the magnitude quotient, negated when exactly one operand is negative.
- R2: In signed mode with a nonzero divisor, `rem_trunc_o` has the magnitude of |A| mod |B|, negated when the dividend is negative.
- R3: In signed mode with a nonzero divisor, `rem_floor_o` equals `rem_trunc_o` when that value is zero or when both operands have the same sign. Otherwise it equals `rem_trunc_o` plus the divisor, modulo 2^W.
- R4: Signed mode applies only when `a_signed_i` and `b_signed_i` are both 1. Any other flag combination divides the zero-extended operands as unsigned numbers, and `rem_floor_o` then equals `rem_trunc_o`.
- R5: The results are W = max(A_WIDTH, B_WIDTH) bits wide. In signed mode the narrower operand is sign-extended to W bits; in unsigned mode it is zero-extended.
- R6: With a zero divisor, both remainders return the dividend. The low min(A_WIDTH, B_WIDTH) bits are copied from `a_i`. The bits above are filled with copies of bit min(A_WIDTH, B_WIDTH)-1 of `a_i` in signed mode, and with zeros in unsigned mode.
- R7: With a zero divisor in unsigned mode, `quot_o` has ones in its low A_WIDTH bits and zeros above. In signed mode it is 1 when the dividend is negative and all ones (minus one) otherwise.
- R8: In signed mode, the most negative W-bit dividend divided by minus one gives a quotient equal to the dividend, and both remainders are zero.
- R9: A start accepted at a clock edge raises `busy_o` after that edge. `done_o` rises exactly W edges later, and `busy_o` falls at the same edge.
- R10: A `start_i` pulse sampled while `busy_o` is high is ignored. The running operation completes on schedule with its original operands.
- R11: `done_o` is high for exactly one cycle. The three result ports change only at the edge that raises `done_o`.
- R12: During reset, `busy_o`, `done_o` and all result ports are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| a_i | input | A_WIDTH | Dividend |
| b_i | input | B_WIDTH | Divisor |
| a_signed_i | input | 1 | Dividend is two's complement |
| b_signed_i | input | 1 | Divisor is two's complement |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-ready pulse |
| quot_o | output | W | Quotient rounded toward zero |
| rem_trunc_o | output | W | Remainder carrying the dividend's sign |
| rem_floor_o | output | W | Remainder carrying the divisor's sign |

## Verification
The bench builds the unit with an 8-bit dividend and a 6-bit divisor, so W is 8 and the two operand widths differ. With these widths, a negative 6-bit divisor must be sign-extended, and a zero-divisor remainder has an upper two bits that are filled rather than copied. The dividend -128 reaches the wrap case against the 6-bit encoding of minus one. The short 8-cycle latency allows hundreds of random operations across all four flag combinations. A start pulse injected mid-operation shows that the running computation is undisturbed.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/sdiv_operand_prep.sv
// Turns one operand into a sign flag and a W-bit unsigned magnitude.
module sdiv_operand_prep #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  val_i,
    input  logic             sext_i,
    output logic             neg_o,
    output logic [OUT_W-1:0] mag_o
);
    logic [OUT_W-1:0] ext;

    assign neg_o = sext_i & val_i[IN_W-1];

    generate
        if (OUT_W > IN_W) begin : g_widen
            assign ext = {{(OUT_W-IN_W){neg_o}}, val_i};
        end else begin : g_same
            assign ext = val_i;
        end
    endgenerate

    // Two's-complement negation; the most negative value maps to 2^(OUT_W-1).
    assign mag_o = neg_o ? (~ext + 1'b1) : ext;
endmodule

// File: rtl/sdiv_step.sv
// One restoring division step: shift in the next dividend bit, try a subtract.
module sdiv_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dq_i,
    input  logic [W-1:0] bmag_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] dq_o
);
    logic [W:0] rem_sh;
    logic       take;

    assign rem_sh = {rem_i, dq_i[W-1]};
    assign take   = (rem_sh >= {1'b0, bmag_i});
    assign rem_o  = take ? W'(rem_sh - {1'b0, bmag_i}) : rem_sh[W-1:0];
    assign dq_o   = {dq_i[W-2:0], take};
endmodule

// File: rtl/sdiv_fixup.sv
// Sign correction of quotient and remainders, plus fixed zero-divisor values.
module sdiv_fixup #(
    parameter int A_W   = 8,
    parameter int W     = 8,
    parameter int MIN_W = 8
) (
    input  logic [W-1:0]     qmag_i,
    input  logic [W-1:0]     rmag_i,
    input  logic [W-1:0]     bmag_i,
    input  logic [MIN_W-1:0] alo_i,
    input  logic             sgn_i,
    input  logic             nega_i,
    input  logic             negb_i,
    input  logic             bzero_i,
    output logic [W-1:0]     quot_o,
    output logic [W-1:0]     rtr_o,
    output logic [W-1:0]     rfl_o
);
    logic [W-1:0] q_norm, rt_norm, rf_norm;
    logic [W-1:0] zero_rem, zero_q_uns, zero_q;
    logic         flip;

    generate
        if (W > MIN_W) begin : g_zr_fill
            assign zero_rem = {{(W-MIN_W){sgn_i & alo_i[MIN_W-1]}}, alo_i};
        end else begin : g_zr_exact
            assign zero_rem = alo_i;
        end
        if (W > A_W) begin : g_zq_pad
            assign zero_q_uns = {{(W-A_W){1'b0}}, {A_W{1'b1}}};
        end else begin : g_zq_full
            assign zero_q_uns = {W{1'b1}};
        end
    endgenerate

    always_comb begin
        q_norm  = (nega_i ^ negb_i) ? (~qmag_i + 1'b1) : qmag_i;
        rt_norm = nega_i ? (~rmag_i + 1'b1) : rmag_i;
        flip    = sgn_i && (rt_norm != '0) && (nega_i != negb_i);
        // Adding a negative divisor equals subtracting its magnitude.
        if (!flip) begin
            rf_norm = rt_norm;
        end else if (negb_i) begin
            rf_norm = rt_norm - bmag_i;
        end else begin
            rf_norm = rt_norm + bmag_i;
        end
        zero_q = sgn_i ? (nega_i ? W'(1) : {W{1'b1}}) : zero_q_uns;

        quot_o = bzero_i ? zero_q   : q_norm;
        rtr_o  = bzero_i ? zero_rem : rt_norm;
        rfl_o  = bzero_i ? zero_rem : rf_norm;
    end
endmodule

// File: rtl/sdiv_floor.sv
module sdiv_floor #(
    parameter int A_WIDTH = 16,
    parameter int B_WIDTH = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [A_WIDTH-1:0]   a_i,
    input  logic [B_WIDTH-1:0]   b_i,
    input  logic                 a_signed_i,
    input  logic                 b_signed_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [((A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH)-1:0] quot_o,
    output logic [((A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH)-1:0] rem_trunc_o,
    output logic [((A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH)-1:0] rem_floor_o
);
    import sdiv_pkg::*;

    localparam int W     = (A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH;
    localparam int MIN_W = (A_WIDTH < B_WIDTH) ? A_WIDTH : B_WIDTH;
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     dq;
        logic [W-1:0]     bmag;
        logic [MIN_W-1:0] alo;
        logic             sgn;
        logic             nega;
        logic             negb;
        logic             bzero;
        logic             done;
        logic [W-1:0]     quot;
        logic [W-1:0]     rtr;
        logic [W-1:0]     rfl;
    } state_t;

    state_t s_d, s_q;

    logic         sgn_in;
    logic         nega_in, negb_in;
    logic [W-1:0] amag_in, bmag_in;
    logic [W-1:0] step_rem, step_dq;
    logic [W-1:0] fix_quot, fix_rtr, fix_rfl;

    assign sgn_in = a_signed_i & b_signed_i;

    sdiv_operand_prep #(.IN_W(A_WIDTH), .OUT_W(W)) u_prep_a (
        .val_i (a_i),
        .sext_i(sgn_in),
        .neg_o (nega_in),
        .mag_o (amag_in)
    );

    sdiv_operand_prep #(.IN_W(B_WIDTH), .OUT_W(W)) u_prep_b (
        .val_i (b_i),
        .sext_i(sgn_in),
        .neg_o (negb_in),
        .mag_o (bmag_in)
    );

    sdiv_step #(.W(W)) u_step (
        .rem_i (s_q.rem),
        .dq_i  (s_q.dq),
        .bmag_i(s_q.bmag),
        .rem_o (step_rem),
        .dq_o  (step_dq)
    );

    sdiv_fixup #(.A_W(A_WIDTH), .W(W), .MIN_W(MIN_W)) u_fix (
        .qmag_i (step_dq),
        .rmag_i (step_rem),
        .bmag_i (s_q.bmag),
        .alo_i  (s_q.alo),
        .sgn_i  (s_q.sgn),
        .nega_i (s_q.nega),
        .negb_i (s_q.negb),
        .bzero_i(s_q.bzero),
        .quot_o (fix_quot),
        .rtr_o  (fix_rtr),
        .rfl_o  (fix_rfl)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_RUN;
                    s_d.cnt   = CNT_W'(W);
                    s_d.rem   = '0;
                    s_d.dq    = amag_in;
                    s_d.bmag  = bmag_in;
                    s_d.alo   = a_i[MIN_W-1:0];
                    s_d.sgn   = sgn_in;
                    s_d.nega  = nega_in;
                    s_d.negb  = negb_in;
                    s_d.bzero = (b_i == '0);
                end
            end
            PH_RUN: begin
                s_d.rem = step_rem;
                s_d.dq  = step_dq;
                s_d.cnt = s_q.cnt - 1'b1;
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                    s_d.quot  = fix_quot;
                    s_d.rtr   = fix_rtr;
                    s_d.rfl   = fix_rfl;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o      = (s_q.phase == PH_RUN);
    assign done_o      = s_q.done;
    assign quot_o      = s_q.quot;
    assign rem_trunc_o = s_q.rtr;
    assign rem_floor_o = s_q.rfl;
endmodule

// File: rtl/sdiv_floor_chk.sv
module sdiv_floor_chk #(
    parameter int A_WIDTH = 16,
    parameter int B_WIDTH = 16
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 start_i,
    input logic [B_WIDTH-1:0]   b_i,
    input logic                 a_signed_i,
    input logic                 b_signed_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [((A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH)-1:0] quot_o,
    input logic [((A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH)-1:0] rem_trunc_o,
    input logic [((A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH)-1:0] rem_floor_o
);
    localparam int W    = (A_WIDTH > B_WIDTH) ? A_WIDTH : B_WIDTH;
    localparam int SN_W = $clog2(W + 1) + 1;

    logic [SN_W-1:0] since_q;
    logic            uns_q;
    logic            bz_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q <= '0;
            uns_q   <= 1'b0;
            bz_q    <= 1'b0;
        end else if (start_i && !busy_o) begin
            since_q <= '0;
            uns_q   <= !(a_signed_i && b_signed_i);
            bz_q    <= (b_i == '0);
        end else if (busy_o) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R9: results appear exactly W edges after an accepted start
    p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (since_q == SN_W'(W)));

    // R9: busy ends only by completing
    p_busy_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (busy_o || done_o));

    p_busy_done_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(quot_o) && $stable(rem_trunc_o) && $stable(rem_floor_o)));

    p_unsigned_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && uns_q) |-> (rem_floor_o == rem_trunc_o));

    p_zero_div_rems_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && bz_q) |-> (rem_floor_o == rem_trunc_o));
endmodule

bind sdiv_floor sdiv_floor_chk #(.A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .b_i        (b_i),
    .a_signed_i (a_signed_i),
    .b_signed_i (b_signed_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .quot_o     (quot_o),
    .rem_trunc_o(rem_trunc_o),
    .rem_floor_o(rem_floor_o)
);

// File: tb/sdiv_floor_tb_top.sv
`timescale 1ns/1ps
module sdiv_floor_tb_top;
    localparam int AW = 8;
    localparam int BW = 6;
    localparam int W  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] a = '0;
    logic [BW-1:0] b = '0;
    logic          as = 1'b0;
    logic          bs = 1'b0;
    logic          busy, done;
    logic [W-1:0]  quot, rtr, rfl;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sdiv_floor #(.A_WIDTH(AW), .B_WIDTH(BW)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .a_i        (a),
        .b_i        (b),
        .a_signed_i (as),
        .b_signed_i (bs),
        .busy_o     (busy),
        .done_o     (done),
        .quot_o     (quot),
        .rem_trunc_o(rtr),
        .rem_floor_o(rfl)
    );

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference using wide integers.
    task automatic ref_div(input logic [AW-1:0] ra, input logic [BW-1:0] rb,
                           input logic ras, input logic rbs,
                           output logic [W-1:0] eq, output logic [W-1:0] ert,
                           output logic [W-1:0] erf,
                           output string tq, output string tr, output string tf);
        longint av, bv, qv, rv, fv;
        logic   sm;
        logic [5:0] lo;
        sm = ras && rbs;
        av = sm ? longint'($signed(ra)) : longint'(ra);
        bv = sm ? longint'($signed(rb)) : longint'(rb);
        if (bv == 0) begin
            lo = ra[5:0];
            rv = sm ? longint'($signed(lo)) : longint'(lo);
            fv = rv;
            if (sm) qv = (av < 0) ? 1 : -1;
            else    qv = (longint'(1) <<< AW) - 1;
            tq = "R7"; tr = "R6"; tf = "R6";
        end else begin
            qv = av / bv;
            rv = av % bv;
            fv = (rv != 0 && ((rv < 0) != (bv < 0))) ? rv + bv : rv;
            if (sm && av == -128 && bv == -1) begin
                tq = "R8"; tr = "R8"; tf = "R8";
            end else if (sm) begin
                tq = rb[BW-1] ? "R5" : "R1"; tr = "R2"; tf = "R3";
            end else begin
                tq = rb[BW-1] ? "R5" : "R4"; tr = "R4"; tf = "R4";
            end
        end
        eq  = W'(qv);
        ert = W'(rv);
        erf = W'(fv);
    endtask

    // Cycle model of the handshake and result registers.
    logic         m_busy = 1'b0;
    logic         m_done = 1'b0;
    int           m_cnt  = 0;
    logic [W-1:0] m_q = '0, m_rt = '0, m_rf = '0;
    logic [W-1:0] p_q = '0, p_rt = '0, p_rf = '0;
    string        m_tq = "R12", m_tr = "R12", m_tf = "R12";
    string        p_tq = "", p_tr = "", p_tf = "";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
            m_q = '0; m_rt = '0; m_rf = '0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                if (start) p_tq = "R10";
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_q = p_q; m_rt = p_rt; m_rf = p_rf;
                    m_tq = p_tq; m_tr = p_tr; m_tf = p_tf;
                end
            end else if (start) begin
                ref_div(a, b, as, bs, p_q, p_rt, p_rf, p_tq, p_tr, p_tf);
                m_busy = 1'b1;
                m_cnt  = W;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9",  "busy", W'(busy), W'(m_busy));
            chk("R11", "done", W'(done), W'(m_done));
            chk(m_tq, "quot", quot, m_q);
            chk(m_tr, "rem_trunc", rtr, m_rt);
            chk(m_tf, "rem_floor", rfl, m_rf);
        end
    end

    task automatic run_op(input logic [AW-1:0] ia, input logic [BW-1:0] ib,
                          input logic ias, input logic ibs, input bit poke);
        @(negedge clk);
        a = ia; b = ib; as = ias; bs = ibs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            a = ~ia; b = ib + 1'b1; as = ~ias; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (m_busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values while reset is asserted
        chk("R12", "busy", W'(busy), '0);
        chk("R12", "done", W'(done), '0);
        chk("R12", "quot", quot, '0);
        chk("R12", "rem_trunc", rtr, '0);
        chk("R12", "rem_floor", rfl, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3: the four sign combinations
        run_op(8'(100),  6'(7),  1'b1, 1'b1, 1'b0);
        run_op(8'(-100), 6'(7),  1'b1, 1'b1, 1'b0);
        run_op(8'(100),  6'(-7), 1'b1, 1'b1, 1'b0);
        run_op(8'(-100), 6'(-7), 1'b1, 1'b1, 1'b0);
        // exact divisions: floored equals truncated when remainder is zero
        run_op(8'(-6), 6'(3), 1'b1, 1'b1, 1'b0);
        run_op(8'(6), 6'(-3), 1'b1, 1'b1, 1'b0);
        run_op(8'(0), 6'(5), 1'b1, 1'b1, 1'b0);
        // R8: wrap case and neighbours
        run_op(8'h80, 6'h3F, 1'b1, 1'b1, 1'b0);
        run_op(8'h80, 6'(1), 1'b1, 1'b1, 1'b0);
        run_op(8'h7F, 6'h3F, 1'b1, 1'b1, 1'b0);
        // R6 R7: zero divisor in each mode
        run_op(8'(45),  6'(0), 1'b1, 1'b1, 1'b0);
        run_op(8'(-3),  6'(0), 1'b1, 1'b1, 1'b0);
        run_op(8'(0),   6'(0), 1'b1, 1'b1, 1'b0);
        run_op(8'(200), 6'(0), 1'b0, 1'b0, 1'b0);
        run_op(8'(45),  6'(0), 1'b0, 1'b1, 1'b0);
        // R4: mixed flags run unsigned
        run_op(8'h9C, 6'(7),  1'b1, 1'b0, 1'b0);
        run_op(8'h9C, 6'h39, 1'b0, 1'b1, 1'b0);
        run_op(8'hFF, 6'h3F, 1'b0, 1'b0, 1'b0);
        // R10: start pulse injected mid-run
        run_op(8'(-77), 6'(9), 1'b1, 1'b1, 1'b1);
        run_op(8'(123), 6'(-5), 1'b1, 1'b1, 1'b1);

        for (int i = 0; i < 300; i++) begin
            run_op(8'($urandom), 6'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule